// File: doc/BRIEF.md
# Locked UDP Transmit Session Controller

This block sits between an on-chip bus receive channel and a UDP/IP transmitter. The bus side presents one 32-bit word at a time. A flag marks address words, an empty flag says whether a word is waiting, and the block answers with a read enable. Each message is an address word, which names the sender, followed by data words. The top nibble of the first data word selects the command.

A transmit configuration sets the destination IP, the destination and source ports, an inactivity limit and a reply address. It also locks the transmit session to the sender. The locked owner can then send data headers, and each header starts one UDP frame. On a frame start the block presents the frame length and addressing, then streams the payload as 16-bit halfwords. The transmitter takes each halfword on a rising edge of its read strobe. The owner frees the session with a release command, and the session is also freed after a configurable period of inactivity.

Top module: `udptx_session`

## Requirements
- R1: `bus_re` is high only in cycles where `bus_empty` is low, and a bus word counts as consumed exactly in a cycle with `bus_re` high. After reset, `bus_re`, `ack_valid`, `tx_new` and `tx_valid` are all low.
- R2: Opcode 0x0 (bits 31:28 of the first word after an address word) opens a four-word configuration. The four words are:
  - word 1: the inactivity limit in bits TO_W-1:0;
  - word 2: the destination IP;
  - word 3: the destination port in bits 31:16 and the source port in bits 15:0;
  - word 4: the reply address.
  If the session is free or already owned by this sender, the block locks the session to the sender. One cycle after the fourth word it pulses `ack_valid` for one cycle with `ack_word` = {8'h58, reply[23:0]}.
- R3: A configuration from a sender other than the current owner gives no acknowledge. It also changes neither the owner nor the frame addressing.
- R4: A data header (opcode 0x1, byte length in bits 27:17) from the owner pulses `tx_new` for one cycle. It presents `tx_len`, `tx_dst_ip`, `tx_dst_port` and `tx_src_port`, and holds them stable while halfwords are being offered.
- R5: A frame of L bytes is sent as ceil(L/2) halfwords taken from ceil(L/4) bus words after the header. Each word gives its low half (bits 15:0) first and its high half second. The unused high half of the last word is discarded.
- R6: A header from a non-owner, a header received while the session is free, or a header with length 0 starts no frame. The words that follow it are consumed and discarded.
- R7: A release (opcode 0x2) from the owner frees the session. A release from any other sender has no effect.
- R8: One halfword is consumed for each low-to-high transition of `tx_rd` while `tx_valid` is high. Holding `tx_rd` high consumes only one halfword.
- R9: Opcode 0x3 and any other unassigned opcode consume the words up to the next address word. They give no acknowledge, start no frame and leave the lock unchanged.
- R10: If the inactivity limit T is nonzero, the lock clears after T consecutive cycles in which no bus word is consumed and no frame is active. If T is 0, the lock never times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_av | input | 1 | Current bus word is an address word |
| bus_data | input | DW | Bus word |
| bus_empty | input | 1 | No bus word is waiting |
| bus_re | output | 1 | Consume the current bus word |
| ack_valid | output | 1 | One-cycle acknowledge strobe |
| ack_word | output | DW | Acknowledge word |
| tx_new | output | 1 | One-cycle frame start strobe |
| tx_len | output | 11 | Frame length in bytes |
| tx_dst_ip | output | 32 | Destination IP address |
| tx_dst_port | output | 16 | Destination UDP port |
| tx_src_port | output | 16 | Source UDP port |
| tx_data | output | DW/2 | Payload halfword |
| tx_valid | output | 1 | `tx_data` holds an unread halfword |
| tx_rd | input | 1 | Read strobe from the transmitter, acted on at its rising edge |

## Verification
If the stored owner or lock bit is wrong, the next header or configuration shows it at once. The header starts a frame when it should have been dropped, or the reverse. The configuration gives or withholds the acknowledge on the cycle after its fourth word. A wrong halfword counter or half selector shows up as too many or too few halfwords captured for a frame, or as a swapped half, and both are checked against values computed per halfword index. A wrong inactivity counter moves the point at which an owner's header stops being accepted. That point is probed on both sides of the configured limit.

// File: rtl/udptx_pkg.sv
package udptx_pkg;
   localparam int LEN_W   = 11;   // byte length field width, bits 27:17 of a header
   localparam int LEN_LSB = 17;
   localparam int IP_W    = 32;
   localparam int PORT_W  = 16;
   localparam logic [7:0] ACK_TAG = 8'h58;

   localparam logic [3:0] OP_TXCFG = 4'h0;
   localparam logic [3:0] OP_HDR   = 4'h1;
   localparam logic [3:0] OP_REL   = 4'h2;

   typedef enum logic [1:0] {
      ST_IDLE,     // discard words until an address word
      ST_CMD,      // next word carries the opcode
      ST_CFG,      // collecting configuration words
      ST_STREAM    // payload words feed the halfword streamer
   } sess_st_e;
endpackage

// File: rtl/udptx_lock.sv
module udptx_lock #(
   parameter int AW   = 32,
   parameter int TO_W = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            grab,
   input  logic [AW-1:0]   grab_addr,
   input  logic [TO_W-1:0] grab_limit,
   input  logic            drop,
   input  logic            active,
   output logic            locked,
   output logic [AW-1:0]   owner
);
   localparam logic [TO_W-1:0] TO_ONE = TO_W'(1);

   logic [TO_W-1:0] limit_q;
   logic [TO_W-1:0] idle_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked  <= 1'b0;
         owner   <= '0;
         limit_q <= '0;
         idle_q  <= '0;
      end else if (grab) begin
         locked  <= 1'b1;
         owner   <= grab_addr;
         limit_q <= grab_limit;
         idle_q  <= '0;
      end else if (drop) begin
         locked <= 1'b0;
         idle_q <= '0;
      end else if (active || !locked) begin
         idle_q <= '0;
      end else if (limit_q != '0) begin
         if (idle_q == limit_q - TO_ONE) begin
            locked <= 1'b0;
            idle_q <= '0;
         end else begin
            idle_q <= idle_q + TO_ONE;
         end
      end
   end
endmodule

// File: rtl/udptx_stream.sv
module udptx_stream #(
   parameter int  DW      = 32,
   parameter int  LEN_W   = 11,
   parameter bit  RD_EDGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] len,
   input  logic             word_ok,
   input  logic [DW-1:0]    word,
   input  logic             tx_rd,
   output logic             want,
   output logic             busy,
   output logic [DW/2-1:0]  tx_data,
   output logic             tx_valid
);
   localparam int HW = DW / 2;
   localparam logic [LEN_W-1:0] L_ONE = LEN_W'(1);

   logic [LEN_W-1:0] left_q;
   logic [DW-1:0]    buf_q;
   logic             full_q;
   logic             hi_q;
   logic             take;
   logic [LEN_W:0]   len_p1;

   generate
      if (RD_EDGE) begin : g_edge
         logic rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= 1'b0;
            else        rd_q <= tx_rd;
         end
         assign take = tx_rd & ~rd_q;
      end else begin : g_level
         assign take = tx_rd;
      end
   endgenerate

   assign len_p1 = {1'b0, len} + (LEN_W+1)'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         buf_q  <= '0;
         full_q <= 1'b0;
         hi_q   <= 1'b0;
      end else if (start) begin
         left_q <= len_p1[LEN_W:1];
         full_q <= 1'b0;
         hi_q   <= 1'b0;
      end else if (word_ok) begin
         buf_q  <= word;
         full_q <= 1'b1;
         hi_q   <= 1'b0;
      end else if (take && full_q) begin
         if (!hi_q && left_q != L_ONE) begin
            hi_q <= 1'b1;
         end else begin
            hi_q   <= 1'b0;
            full_q <= 1'b0;
         end
         left_q <= left_q - L_ONE;
      end
   end

   assign busy     = (left_q != '0);
   assign want     = busy & ~full_q;
   assign tx_valid = full_q;
   assign tx_data  = hi_q ? buf_q[DW-1:HW] : buf_q[HW-1:0];
endmodule

// File: rtl/udptx_session.sv
module udptx_session
   import udptx_pkg::*;
#(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int TO_W    = 20,
   parameter bit RD_EDGE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_av,
   input  logic [DW-1:0]       bus_data,
   input  logic                bus_empty,
   output logic                bus_re,
   output logic                ack_valid,
   output logic [DW-1:0]       ack_word,
   output logic                tx_new,
   output logic [LEN_W-1:0]    tx_len,
   output logic [IP_W-1:0]     tx_dst_ip,
   output logic [PORT_W-1:0]   tx_dst_port,
   output logic [PORT_W-1:0]   tx_src_port,
   output logic [DW/2-1:0]     tx_data,
   output logic                tx_valid,
   input  logic                tx_rd
);
   generate
      if (DW != 32) begin : g_bad_dw
         $error("udptx_session: command fields assume a 32-bit bus word");
      end
      if (AW < 1 || AW > DW) begin : g_bad_aw
         $error("udptx_session: AW must lie in 1..DW");
      end
      if (TO_W < 1 || TO_W > DW - 4) begin : g_bad_to
         $error("udptx_session: TO_W must leave room for the opcode");
      end
   endgenerate

   sess_st_e        st_q;
   logic [AW-1:0]   src_q;
   logic [1:0]      idx_q;
   logic [TO_W-1:0] cfg_to_q;
   logic [IP_W-1:0] cfg_ip_q;
   logic [DW-1:0]   cfg_ports_q;

   logic            acc, is_cmd, own_ok, locked;
   logic [AW-1:0]   owner;
   logic [3:0]      op;
   logic [LEN_W-1:0] hdr_len;
   logic            grab, drop, start;
   logic            s_want, s_busy;

   assign op      = bus_data[DW-1:DW-4];
   assign hdr_len = bus_data[LEN_LSB+LEN_W-1:LEN_LSB];
   assign bus_re  = ~bus_empty & ((st_q == ST_STREAM) ? s_want : 1'b1);
   assign acc     = bus_re;
   assign is_cmd  = acc && !bus_av && st_q == ST_CMD;
   assign own_ok  = locked && owner == src_q;

   assign grab  = acc && !bus_av && st_q == ST_CFG && idx_q == 2'd3 &&
                  (!locked || owner == src_q);
   assign drop  = is_cmd && op == OP_REL && own_ok;
   assign start = is_cmd && op == OP_HDR && own_ok && hdr_len != '0;

   udptx_lock #(.AW(AW), .TO_W(TO_W)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .grab      (grab),
      .grab_addr (src_q),
      .grab_limit(cfg_to_q),
      .drop      (drop),
      .active    (acc | s_busy),
      .locked    (locked),
      .owner     (owner)
   );

   udptx_stream #(.DW(DW), .LEN_W(LEN_W), .RD_EDGE(RD_EDGE)) u_stream (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .len     (hdr_len),
      .word_ok (acc && st_q == ST_STREAM),
      .word    (bus_data),
      .tx_rd   (tx_rd),
      .want    (s_want),
      .busy    (s_busy),
      .tx_data (tx_data),
      .tx_valid(tx_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         src_q       <= '0;
         idx_q       <= '0;
         cfg_to_q    <= '0;
         cfg_ip_q    <= '0;
         cfg_ports_q <= '0;
         ack_valid   <= 1'b0;
         ack_word    <= '0;
         tx_new      <= 1'b0;
         tx_len      <= '0;
         tx_dst_ip   <= '0;
         tx_dst_port <= '0;
         tx_src_port <= '0;
      end else begin
         ack_valid <= grab;
         tx_new    <= start;
         if (grab) begin
            ack_word    <= {ACK_TAG, bus_data[23:0]};
            tx_dst_ip   <= cfg_ip_q;
            tx_dst_port <= cfg_ports_q[DW-1:DW/2];
            tx_src_port <= cfg_ports_q[DW/2-1:0];
         end
         if (st_q == ST_STREAM) begin
            if (!s_busy) st_q <= ST_IDLE;
         end else if (acc && bus_av) begin
            src_q <= bus_data[AW-1:0];
            st_q  <= ST_CMD;
         end else if (acc) begin
            case (st_q)
               ST_CMD: begin
                  if (op == OP_TXCFG) begin
                     cfg_to_q <= bus_data[TO_W-1:0];
                     idx_q    <= 2'd1;
                     st_q     <= ST_CFG;
                  end else if (start) begin
                     tx_len <= hdr_len;
                     st_q   <= ST_STREAM;
                  end else begin
                     st_q <= ST_IDLE;
                  end
               end
               ST_CFG: begin
                  if (idx_q == 2'd1) cfg_ip_q    <= bus_data;
                  if (idx_q == 2'd2) cfg_ports_q <= bus_data;
                  idx_q <= idx_q + 2'd1;
                  if (idx_q == 2'd3) st_q <= ST_IDLE;
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/udptx_session_chk.sv
module udptx_session_chk #(
   parameter int DW      = 32,
   parameter int LEN_W   = 11,
   parameter bit RD_EDGE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_empty,
   input logic             bus_re,
   input logic             ack_valid,
   input logic [DW-1:0]    ack_word,
   input logic             tx_new,
   input logic [LEN_W-1:0] tx_len,
   input logic [31:0]      tx_dst_ip,
   input logic [15:0]      tx_dst_port,
   input logic [15:0]      tx_src_port,
   input logic [DW/2-1:0]  tx_data,
   input logic             tx_valid,
   input logic             tx_rd
);
   AST_RE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      bus_empty |-> !bus_re);                                               // R1
   AST_ACK_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> ack_word[DW-1:DW-8] == 8'h58);                          // R2
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |=> !ack_valid);                                            // R2
   AST_NEW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_new |=> !tx_new);                                                  // R4
   AST_NEW_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      tx_new |-> !tx_valid);                                                // R4
   AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && $past(tx_valid)) |-> ($stable(tx_len) && $stable(tx_dst_ip) &&
         $stable(tx_dst_port) && $stable(tx_src_port)));                    // R4

   generate
      if (RD_EDGE) begin : g_edge_chk
         AST_ONE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_valid && tx_rd && $past(tx_rd)) |=> (tx_valid && $stable(tx_data))); // R8
      end
   endgenerate
endmodule

bind udptx_session udptx_session_chk #(
   .DW(DW), .LEN_W(udptx_pkg::LEN_W), .RD_EDGE(RD_EDGE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_empty(bus_empty), .bus_re(bus_re),
   .ack_valid(ack_valid), .ack_word(ack_word), .tx_new(tx_new), .tx_len(tx_len),
   .tx_dst_ip(tx_dst_ip), .tx_dst_port(tx_dst_port), .tx_src_port(tx_src_port),
   .tx_data(tx_data), .tx_valid(tx_valid), .tx_rd(tx_rd)
);

// File: tb/udptx_session_bench.sv
module udptx_session_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_av = 1'b0;
   logic [31:0] bus_data = '0;
   logic        bus_empty = 1'b1;
   logic        bus_re;
   logic        ack_valid;
   logic [31:0] ack_word;
   logic        tx_new;
   logic [10:0] tx_len;
   logic [31:0] tx_dst_ip;
   logic [15:0] tx_dst_port, tx_src_port, tx_data;
   logic        tx_valid;
   logic        tx_rd = 1'b0;

   always #5 clk = ~clk;

   udptx_session #(.AW(32), .DW(32), .TO_W(20), .RD_EDGE(1'b1)) u_udptx_session (
      .clk(clk), .rst_n(rst_n), .bus_av(bus_av), .bus_data(bus_data),
      .bus_empty(bus_empty), .bus_re(bus_re), .ack_valid(ack_valid),
      .ack_word(ack_word), .tx_new(tx_new), .tx_len(tx_len),
      .tx_dst_ip(tx_dst_ip), .tx_dst_port(tx_dst_port), .tx_src_port(tx_src_port),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_rd(tx_rd)
   );

   int checks = 0, errors = 0;
   int nnew = 0, nack = 0, ncap = 0;
   logic [31:0] last_ack, last_ip;
   logic [15:0] last_dp, last_sp;
   int          last_len;
   logic [15:0] cap [0:511];
   logic [31:0] msg [0:31];
   bit          auto_rd = 1'b1;

   localparam logic [31:0] A = 32'h0123_4567;
   localparam logic [31:0] B = 32'h1234_5678;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // monitor and automatic halfword reader
   initial forever begin
      @(negedge clk);
      if (tx_new) begin
         nnew++; last_len = int'(tx_len); last_ip = tx_dst_ip;
         last_dp = tx_dst_port; last_sp = tx_src_port;
      end
      if (ack_valid) begin nack++; last_ack = ack_word; end
      if (auto_rd) begin
         if (tx_rd) tx_rd = 1'b0;
         else if (tx_valid) begin
            if (ncap < 512) cap[ncap] = tx_data;
            ncap++;
            tx_rd = 1'b1;
         end
      end
   end

   task automatic put_word(input logic av, input logic [31:0] d);
      bit taken = 1'b0;
      bus_av = av; bus_data = d; bus_empty = 1'b0;
      while (!taken) begin
         #1; taken = bus_re;
         @(negedge clk);
      end
   endtask

   task automatic send_msg(input logic [31:0] addr, input int n);
      put_word(1'b1, addr);
      for (int i = 0; i < n; i++) put_word(1'b0, msg[i]);
      bus_empty = 1'b1; bus_av = 1'b0;
   endtask

   task automatic send_cfg(input logic [31:0] addr, input logic [31:0] to,
                           input logic [31:0] ip, input logic [31:0] ports,
                           input logic [31:0] reply);
      msg[0] = {4'h0, to[27:0]}; msg[1] = ip; msg[2] = ports; msg[3] = reply;
      send_msg(addr, 4);
      repeat (3) @(negedge clk);
   endtask

   task automatic run_frame(input logic [31:0] addr, input int len, input logic [15:0] base,
                            input bit expect_frame, input string req);
      int h = (len + 1) / 2;
      int w = (h + 1) / 2;
      int n0 = nnew;
      int c0 = ncap;
      msg[0] = {4'h1, 11'(len), 17'h0};
      for (int k = 0; k < w; k++)
         msg[k+1] = {base + 16'(6*k + 3), base + 16'(6*k)};
      send_msg(addr, w + 1);
      repeat (12) @(negedge clk);
      if (expect_frame) begin
         chk(nnew == n0 + 1, req, "frame start count", nnew, n0 + 1);
         chk(last_len == len, req, "frame length", last_len, len);
         chk(ncap - c0 == h, req, "halfword count", ncap - c0, h);
         for (int j = 0; j < h; j++)
            chk(cap[c0+j] == base + 16'(3*j), "R5", "halfword value",
                cap[c0+j], base + 16'(3*j));
      end else begin
         chk(nnew == n0, req, "no frame start", nnew, n0);
         chk(ncap == c0, req, "no halfwords", ncap, c0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
   end

   initial begin
      int n0;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(bus_re == 0, "R1", "bus_re after reset", bus_re, 0);
      chk(tx_valid == 0 && tx_new == 0, "R1", "tx strobes after reset", {tx_valid, tx_new}, 0);
      chk(ack_valid == 0, "R1", "ack after reset", ack_valid, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(bus_re == 0, "R1", "bus_re while empty", bus_re, 0);

      // R2 configuration from A locks and acknowledges
      send_cfg(A, 0, 32'hACDC_ABBA, 32'h0101_AAAA, 32'h0082_FAAC);
      chk(nack == 1, "R2", "ack count", nack, 1);
      chk(last_ack == 32'h5882_FAAC, "R2", "ack word", last_ack, 32'h5882_FAAC);

      // R4/R5 long odd frame, then short ones
      run_frame(A, 107, 16'h0100, 1, "R4");
      chk(last_ip == 32'hACDC_ABBA, "R4", "dest ip", last_ip, 32'hACDC_ABBA);
      chk(last_dp == 16'h0101 && last_sp == 16'hAAAA, "R4", "ports",
          {last_dp, last_sp}, 32'h0101_AAAA);
      run_frame(A, 5, 16'h2000, 1, "R5");
      run_frame(A, 12, 16'h3000, 1, "R5");

      // R6 non-owner header and zero length
      run_frame(B, 12, 16'h4000, 0, "R6");
      run_frame(A, 0, 16'h4100, 0, "R6");

      // R3 foreign configuration ignored
      n0 = nack;
      send_cfg(B, 0, 32'h1111_2222, 32'h3333_4444, 32'h0000_0055);
      chk(nack == n0, "R3", "foreign cfg ack", nack, n0);
      run_frame(A, 4, 16'h5000, 1, "R3");
      chk(last_ip == 32'hACDC_ABBA, "R3", "dest ip unchanged", last_ip, 32'hACDC_ABBA);

      // R9 receive configuration and unknown opcode
      n0 = nack;
      msg[0] = 32'h3000_0000; msg[1] = 32'h1234_5678; msg[2] = 32'h3232_2323; msg[3] = 32'h0080_ABBA;
      send_msg(A, 4);
      msg[0] = 32'hF000_0000; msg[1] = 32'h1000_0000;
      send_msg(A, 2);
      repeat (5) @(negedge clk);
      chk(nack == n0, "R9", "no ack for other opcodes", nack, n0);
      run_frame(A, 6, 16'h6000, 1, "R9");

      // R7 release
      msg[0] = 32'h2000_0000; send_msg(B, 1);
      run_frame(A, 2, 16'h7000, 1, "R7");
      msg[0] = 32'h2000_0000; send_msg(A, 1);
      run_frame(A, 4, 16'h7100, 0, "R7");
      run_frame(B, 4, 16'h7200, 0, "R6");

      // B takes the free session, no timeout
      n0 = nack;
      send_cfg(B, 0, 32'h0A0B_0C0D, 32'h1111_2222, 32'h0077_1234);
      chk(nack == n0 + 1, "R2", "cfg after release acked", nack, n0 + 1);
      repeat (100) @(negedge clk);
      run_frame(B, 8, 16'h8000, 1, "R10");
      chk(last_ip == 32'h0A0B_0C0D, "R2", "new dest ip", last_ip, 32'h0A0B_0C0D);
      run_frame(A, 8, 16'h8100, 0, "R6");

      // R8 held read strobe consumes one halfword
      auto_rd = 1'b0;
      n0 = ncap;
      msg[0] = {4'h1, 11'd4, 17'h0}; msg[1] = 32'hBEEF_CAFE;
      send_msg(B, 2);
      repeat (3) @(negedge clk);
      chk(tx_valid == 1 && tx_data == 16'hCAFE, "R8", "first half offered", tx_data, 16'hCAFE);
      tx_rd = 1'b1;
      repeat (5) @(negedge clk);
      chk(tx_valid == 1, "R8", "valid while held", tx_valid, 1);
      chk(tx_data == 16'hBEEF, "R8", "one half per edge", tx_data, 16'hBEEF);
      tx_rd = 1'b0; @(negedge clk);
      tx_rd = 1'b1; @(negedge clk);
      tx_rd = 1'b0; @(negedge clk);
      chk(tx_valid == 0, "R8", "frame drained", tx_valid, 0);
      auto_rd = 1'b1;

      // R10 inactivity limit
      msg[0] = 32'h2000_0000; send_msg(B, 1);
      send_cfg(A, 30, 32'hC0A8_0001, 32'h0050_1F90, 32'h0000_0042);
      repeat (20) @(negedge clk);
      run_frame(A, 4, 16'h9000, 1, "R10");
      repeat (40) @(negedge clk);
      run_frame(A, 4, 16'h9100, 0, "R10");
      n0 = nack;
      send_cfg(B, 0, 32'h0101_0101, 32'h0001_0002, 32'h0000_0099);
      chk(nack == n0 + 1, "R10", "session free after timeout", nack, n0 + 1);

      summary();
   end
endmodule